// File: doc/BRIEF.md
# SHA-512 Block Compression Engine

This block runs the SHA-512 compression function on one 1024-bit message block. It takes a 512-bit chaining value and the block on a single accepted `start_i`, runs eighty rounds at one round per clock, adds the result to the captured chaining value, and shows the new chaining value on `hash_o` along with a one-cycle `done_o` pulse. Padding, fetching the message, chaining several blocks together and the initial hash constants are left to the logic around it.

The message schedule sits in a rolling buffer of sixteen 64-bit words and is rewritten in place after each group of sixteen rounds. Earlier rewrites within a batch feed the later ones. The `SERIAL_SCHED` parameter selects how that rewrite is done. With 0, all sixteen words are updated in the same clock as round 15, 31, 47 or 63, and no extra cycles are spent. With 1, one word is updated per cycle, which adds 16 cycles per batch but keeps only one schedule adder chain. Both settings give the same hash. The 80 round constants are computed at elaboration from the fractional cube roots of the first 80 primes.

Top module: `sha512_compress`

## Requirements
- R1: While `rst_ni` is low, and after reset, `busy_o` is 0, `done_o` is 0 and `hash_o` is all zeros.
- R2: `hash_o` equals the SHA-512 compression of `chain_i` and `block_i`, captured at the accepted start. Word 0 of each bus is its most significant 64 bits: `chain_i[511:448]` is working word a, and `block_i[1023:960]` is schedule word 0.
- R3: Each schedule batch updates word j for j = 0..15 in ascending order. A word updated earlier in the batch is the value seen by later updates, so the result equals the textbook 80-word expansion.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: `done_o` rises 81 clock edges after the accepting edge when `SERIAL_SCHED` = 0, and 145 edges after it when `SERIAL_SCHED` = 1.
- R6: `start_i` has no effect while `busy_o` is high. The running result, its latency and the number of `done_o` pulses do not change.
- R7: `chain_i` and `block_i` are registered at the accepted start. Changing them later has no effect on `hash_o`.
- R8: `hash_o` holds its value in every cycle except the one in which `done_o` rises.
- R9: Every addition wraps modulo 2^64, and carries never cross between words.
- R10: `busy_o` rises on the edge that accepts `start_i` (start high while idle) and falls on the same edge on which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a compression; accepted only when idle |
| chain_i | input | 512 | Input chaining value, word a in the top bits |
| block_i | input | 1024 | Message block, word 0 in the top bits |
| busy_o | output | 1 | Compression in progress |
| done_o | output | 1 | One-cycle pulse when `hash_o` is updated |
| hash_o | output | 512 | Output chaining value, word a in the top bits |

## Verification
A wrong working register, schedule word or round constant is not visible at the ports until the final addition. It then corrupts `hash_o` in the cycle that `done_o` rises, which is 81 or 145 edges after start, and it almost always changes every word of the output because of the mixing between rounds. A schedule batch done in the wrong order, or with stale operands, differs from the 80-word expansion in the reference from round 16 onward. A wrong round counter or a missed state transition shows up as a moved or missing `done_o` pulse, or as `busy_o` out of step with that pulse. Both schedule variants are run side by side on the same stimulus.

// File: rtl/sha512_pkg.sv
package sha512_pkg;
  localparam int WORD_W    = 64;
  localparam int CV_WORDS  = 8;
  localparam int BLK_WORDS = 16;
  localparam int ROUNDS    = 80;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [0:CV_WORDS-1][WORD_W-1:0]  state_t;
  typedef logic [0:BLK_WORDS-1][WORD_W-1:0] block_t;

  function automatic word_t rotr(word_t x, int n);
    logic [2*WORD_W-1:0] d;
    d = {x, x} >> n;
    return d[WORD_W-1:0];
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t small_s0(word_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic word_t small_s1(word_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic word_t choose(word_t x, word_t y, word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(word_t x, word_t y, word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // n-th prime, counting from 0 (0 -> 2)
  function automatic int nth_prime(int n);
    int cnt;
    int found;
    bit isp;
    cnt   = 0;
    found = 2;
    for (int c = 2; c < 512; c++) begin
      isp = 1'b1;
      for (int d = 2; d < 23; d++)
        if (d * d <= c && c % d == 0) isp = 1'b0;
      if (isp) begin
        if (cnt == n) found = c;
        cnt++;
      end
    end
    return found;
  endfunction

  // fractional 64 bits of the cube root of the idx-th prime
  function automatic word_t round_const(int idx);
    logic [255:0] lim;
    logic [255:0] x;
    logic [255:0] t;
    lim = 256'(nth_prime(idx));
    lim = lim << 192;
    x   = '0;
    for (int b = 66; b >= 0; b--) begin
      t = x | (256'd1 << b);
      if (t * t * t <= lim) x = t;
    end
    return x[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/sha512_krom.sv
module sha512_krom
  import sha512_pkg::*;
#(
  parameter  int NUM   = ROUNDS,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic [IDX_W-1:0] idx_i,
  output word_t            k_o
);
  word_t tab [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_k
    localparam word_t KV = round_const(g);
    assign tab[g] = KV;
  end

  assign k_o = (int'(idx_i) < NUM) ? tab[idx_i] : '0;
endmodule

// File: rtl/sha512_round.sv
module sha512_round
  import sha512_pkg::*;
(
  input  state_t st_i,
  input  word_t  k_i,
  input  word_t  w_i,
  output state_t st_o
);
  word_t t1;
  word_t t2;

  assign t1 = st_i[7] + big_s1(st_i[4]) + choose(st_i[4], st_i[5], st_i[6]) + k_i + w_i;
  assign t2 = big_s0(st_i[0]) + majority(st_i[0], st_i[1], st_i[2]);

  assign st_o = {t1 + t2, st_i[0], st_i[1], st_i[2],
                 st_i[3] + t1, st_i[4], st_i[5], st_i[6]};
endmodule

// File: rtl/sha512_sched.sv
module sha512_sched
  import sha512_pkg::*;
#(
  parameter  bit SERIAL = 1'b0,
  localparam int IDX_W  = $clog2(BLK_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  block_t           blk_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output word_t            w_o,
  output logic             last_o
);
  block_t w_q;

  function automatic word_t mix(block_t w, int j);
    return w[j] + w[(j + 9) % BLK_WORDS] + small_s0(w[(j + 1) % BLK_WORDS])
         + small_s1(w[(j + 14) % BLK_WORDS]);
  endfunction

  assign w_o = w_q[rd_idx_i];

  if (SERIAL) begin : g_ser
    logic [IDX_W-1:0] j_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q <= '0;
        j_q <= '0;
      end else if (load_i) begin
        w_q <= blk_i;
        j_q <= '0;
      end else if (adv_i) begin
        w_q[j_q] <= mix(w_q, int'(j_q));
        j_q      <= j_q + 1'b1;
      end
    end

    assign last_o = adv_i && (j_q == IDX_W'(BLK_WORDS - 1));
  end else begin : g_par
    block_t nxt;

    // chained so that word j sees the words updated before it
    always_comb begin
      nxt = w_q;
      for (int j = 0; j < BLK_WORDS; j++) nxt[j] = mix(nxt, j);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     w_q <= '0;
      else if (load_i) w_q <= blk_i;
      else if (adv_i)  w_q <= nxt;
    end

    assign last_o = adv_i;
  end
endmodule

// File: rtl/sha512_compress.sv
module sha512_compress
  import sha512_pkg::*;
#(
  parameter  bit SERIAL_SCHED = 1'b0,
  localparam int RND_W  = $clog2(ROUNDS),
  localparam int SIDX_W = $clog2(BLK_WORDS),
  localparam int CV_W   = CV_WORDS * WORD_W,
  localparam int BLK_W  = BLK_WORDS * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CV_W-1:0]  chain_i,
  input  logic [BLK_W-1:0] block_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CV_W-1:0]  hash_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_SCHED, ST_FINAL} st_e;

  st_e              st_q;
  logic [RND_W-1:0] rnd_q;
  state_t           work_q;
  state_t           cv_q;
  state_t           work_nxt;
  state_t           sum;
  logic [CV_W-1:0]  hash_q;
  logic             done_q;
  word_t            k_cur;
  word_t            w_cur;
  logic             grp_end;
  logic             is_last;
  logic             sched_adv;
  logic             sched_last;
  logic             accept;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign grp_end = &rnd_q[SIDX_W-1:0];
  assign is_last = rnd_q == RND_W'(ROUNDS - 1);

  if (SERIAL_SCHED) begin : g_adv_ser
    assign sched_adv = (st_q == ST_SCHED);
  end else begin : g_adv_par
    assign sched_adv = (st_q == ST_ROUND) && grp_end && !is_last;
  end

  sha512_krom #(.NUM(ROUNDS)) u_krom (
    .idx_i (rnd_q),
    .k_o   (k_cur)
  );

  sha512_sched #(.SERIAL(SERIAL_SCHED)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .blk_i    (block_t'(block_i)),
    .adv_i    (sched_adv),
    .rd_idx_i (rnd_q[SIDX_W-1:0]),
    .w_o      (w_cur),
    .last_o   (sched_last)
  );

  sha512_round u_round (
    .st_i (work_q),
    .k_i  (k_cur),
    .w_i  (w_cur),
    .st_o (work_nxt)
  );

  for (genvar g = 0; g < CV_WORDS; g++) begin : g_sum
    assign sum[g] = cv_q[g] + work_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      work_q <= '0;
      cv_q   <= '0;
      hash_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          cv_q   <= state_t'(chain_i);
          work_q <= state_t'(chain_i);
          rnd_q  <= '0;
          st_q   <= ST_ROUND;
        end
        ST_ROUND: begin
          work_q <= work_nxt;
          rnd_q  <= rnd_q + 1'b1;
          if (is_last)                    st_q <= ST_FINAL;
          else if (grp_end && SERIAL_SCHED) st_q <= ST_SCHED;
        end
        ST_SCHED: if (sched_last) st_q <= ST_ROUND;
        ST_FINAL: begin
          hash_q <= sum;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign hash_o = hash_q;
endmodule

// File: rtl/sha512_compress_chk.sv
module sha512_compress_chk
  import sha512_pkg::*;
#(
  parameter  bit SERIAL_SCHED = 1'b0,
  localparam int LATENCY = ROUNDS + 1
                         + (SERIAL_SCHED ? (ROUNDS / BLK_WORDS - 1) * BLK_WORDS : 0),
  localparam int CNT_W   = $clog2(LATENCY + 1) + 1,
  localparam int CV_W    = CV_WORDS * WORD_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [CV_W-1:0] hash_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= '0;
    else if (busy_o)            cnt_q <= cnt_q + 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_START_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R10
  AST_HASH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(hash_o)); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_q == CNT_W'(LATENCY)); // R5
endmodule

bind sha512_compress sha512_compress_chk #(.SERIAL_SCHED(SERIAL_SCHED)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hash_o  (hash_o)
);

// File: tb/sha512_compress_bench.sv
`timescale 1ns/1ps
module sha512_compress_bench;
  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [511:0]  chain_i = '0;
  logic [1023:0] block_i = '0;
  logic          busy_c, done_c, busy_s, done_s;
  logic [511:0]  hash_c, hash_s;
  int            total = 0;
  int            fails = 0;
  logic [63:0]   kb [80];
  logic [63:0]   rng = 64'h9e3779b97f4a7c15;

  always #4 clk = ~clk;

  sha512_compress #(.SERIAL_SCHED(1'b0)) u_sha512_compress (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chain_i(chain_i),
    .block_i(block_i), .busy_o(busy_c), .done_o(done_c), .hash_o(hash_c));

  sha512_compress #(.SERIAL_SCHED(1'b1)) u_sha512_compress_ser (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .chain_i(chain_i),
    .block_i(block_i), .busy_o(busy_s), .done_o(done_s), .hash_o(hash_s));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] bench_k(int idx);
    int p, seen;
    logic [255:0] lo, hi, mid, lim;
    p = 1; seen = -1;
    while (seen < idx) begin
      bit pr;
      p++;
      pr = 1'b1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) pr = 1'b0;
      if (pr) seen++;
    end
    lim = 256'(p) << 192;
    lo = 256'd1 << 64;
    hi = 256'd8 << 64;
    while (hi - lo > 1) begin
      mid = (lo + hi) >> 1;
      if (mid * mid * mid <= lim) lo = mid; else hi = mid;
    end
    return lo[63:0];
  endfunction

  // textbook 80-word expansion as reference
  function automatic logic [511:0] ref_hash(logic [511:0] cv, logic [1023:0] blk);
    logic [63:0] x [80];
    logic [63:0] v [8];
    logic [63:0] h [8];
    logic [63:0] t1, t2;
    logic [511:0] res;
    for (int i = 0; i < 16; i++) x[i] = blk[1023-64*i -: 64];
    for (int i = 16; i < 80; i++)
      x[i] = (rr(x[i-2], 19) ^ rr(x[i-2], 61) ^ (x[i-2] >> 6)) + x[i-7]
           + (rr(x[i-15], 1) ^ rr(x[i-15], 8) ^ (x[i-15] >> 7)) + x[i-16];
    for (int i = 0; i < 8; i++) begin
      h[i] = cv[511-64*i -: 64];
      v[i] = h[i];
    end
    for (int r = 0; r < 80; r++) begin
      t1 = v[7] + (rr(v[4], 14) ^ rr(v[4], 18) ^ rr(v[4], 41))
         + ((v[4] & v[5]) | (~v[4] & v[6])) + kb[r] + x[r];
      t2 = (rr(v[0], 28) ^ rr(v[0], 34) ^ rr(v[0], 39))
         + ((v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) res[511-64*i -: 64] = h[i] + v[i];
    return res;
  endfunction

  function automatic logic [63:0] next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // mode 0: plain, 1: inputs change after accept (R7), 2: start held while busy (R6)
  task automatic run_vec(input logic [511:0] cv, input logic [1023:0] blk,
                         input int mode, input string req);
    logic [511:0] exp, got_c, got_s;
    int lat_c, lat_s, dn_c, dn_s;
    exp = ref_hash(cv, blk);
    lat_c = 0; lat_s = 0; dn_c = 0; dn_s = 0;
    got_c = '0; got_s = '0;
    @(negedge clk);
    chain_i = cv; block_i = blk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_c && busy_s, "R10", "busy after accept", {510'd0, busy_c, busy_s}, 512'd3);
    if (mode != 0) begin
      chain_i = ~cv;
      block_i = ~blk;
    end
    for (int cyc = 1; cyc <= 160; cyc++) begin
      start_i = (mode == 2) && (cyc <= 20);
      @(negedge clk);
      if (done_c) begin dn_c++; if (lat_c == 0) begin lat_c = cyc; got_c = hash_c; end end
      if (done_s) begin dn_s++; if (lat_s == 0) begin lat_s = cyc; got_s = hash_s; end end
    end
    start_i = 1'b0;
    chk(got_c == exp, req, "hash parallel schedule", got_c, exp);
    chk(got_s == exp, req, "hash serial schedule", got_s, exp);
    chk(lat_c == 81, "R5", "latency parallel", 512'(lat_c), 512'd81);
    chk(lat_s == 145, "R5", "latency serial", 512'(lat_s), 512'd145);
    chk(dn_c == 1 && dn_s == 1, "R4", "done pulse count", 512'(dn_c * 16 + dn_s), 512'd17);
    chk(hash_c == got_c && hash_s == got_s, "R8", "hash held", hash_c, got_c);
    chk(!busy_c && !busy_s, "R10", "idle at end", {510'd0, busy_c, busy_s}, 512'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL R5 watchdog: actual no completion expected finish before 20000 cycles");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [511:0]  cv;
    logic [1023:0] blk;
    for (int i = 0; i < 80; i++) kb[i] = bench_k(i);
    chk(kb[0] == 64'h428a2f98d728ae22, "R2", "bench constant 0", 512'(kb[0]), 512'h428a2f98d728ae22);
    chk(kb[79] == 64'h6c44198c4a475817, "R2", "bench constant 79", 512'(kb[79]), 512'h6c44198c4a475817);

    repeat (3) @(negedge clk);
    chk(!busy_c && !busy_s && !done_c && !done_s, "R1", "flags in reset",
        {508'd0, busy_c, busy_s, done_c, done_s}, 512'd0);
    chk(hash_c == '0 && hash_s == '0, "R1", "hash in reset", hash_c | hash_s, 512'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_c && !busy_s && !done_c && !done_s, "R1", "flags after reset",
        {508'd0, busy_c, busy_s, done_c, done_s}, 512'd0);

    run_vec('0, '0, 0, "R2");
    run_vec('1, '1, 0, "R9");
    for (int i = 0; i < 8; i++) cv[511-64*i -: 64] = 64'(i + 1);
    for (int i = 0; i < 16; i++) blk[1023-64*i -: 64] = {8{8'(i)}};
    run_vec(cv, blk, 0, "R3");
    for (int v = 0; v < 6; v++) begin
      for (int i = 0; i < 8; i++) cv[511-64*i -: 64] = next_rand();
      for (int i = 0; i < 16; i++) blk[1023-64*i -: 64] = next_rand();
      run_vec(cv, blk, (v == 4) ? 1 : (v == 5) ? 2 : 0,
              (v == 4) ? "R7" : (v == 5) ? "R6" : "R2");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule